// File: doc/BRIEF.md
# CPU Exception Priority Controller

This block sits next to a simple CPU sequencer and decides, at each instruction boundary, which exception the sequencer must enter next. Five exception kinds compete under a fixed ranking: system reset, single-step trace, external interrupt, direct power-state transition and software trap. The controller issues one grant at a time as a one-hot vector with a single-cycle start pulse. It holds a busy flag until the sequencer reports that the handler has finished.

A boundary is either an instruction-complete strobe while idle or a handler-done strobe while busy. Trace, direct-transition and trap requests are held in the block until they are granted. The interrupt line is sampled as a level only at a boundary. Interrupt sampling is suppressed after the condition-flag instructions and after the reset handler. The reset exception does not wait for a boundary. It is raised when the reset input is released or when the watchdog overflows, and it discards every held request.

Top module: `exc_arbiter`

## Requirements
- R1: While `ext_rst` is high, `exc_grant` is 0, `exc_start` is 0 and `exc_busy` is 0. Any trap, trace or sleep request seen during that time is discarded.
- R2: In the first cycle that samples `ext_rst` low after it was high, the next clock edge sets `exc_grant` to 5'b00001 (reset), pulses `exc_start` and raises `exc_busy`.
- R3: A `wdt_ovf` pulse, sampled with `ext_rst` low, grants reset (5'b00001) at the next edge even when a handler is running. It also discards every held trace, direct-transition and trap request.
- R4: Grant bits are reset = bit 0, trace = bit 1, interrupt = bit 2, direct transition = bit 3 and trap = bit 4. At a boundary the lowest-numbered eligible request wins. The losers stay held and are granted at later boundaries in that order.
- R5: An `insn_done` strobe while not busy, with `trace_en` high, creates a trace request. That request is eligible at the same boundary.
- R6: `irq` is a level that the block never stores. It causes a grant only if it is high in the boundary cycle itself.
- R7: The interrupt is not eligible at an `insn_done` boundary whose `insn_cls` is 1, 2, 3 or 4 (flag AND, OR, XOR, load). Other class codes do not mask it.
- R8: The interrupt is not eligible at the `hdl_done` boundary that ends a reset handler.
- R9: A `sleep_exec` strobe with `direct_mode` high creates a held direct-transition request. With `direct_mode` low, the strobe has no effect.
- R10: A `trap_stb` strobe is held whenever `ext_rst` is low, including while busy. It is never masked by the instruction class.
- R11: `exc_busy` stays high and `exc_grant` stays constant from a grant until `hdl_done`. `hdl_done` with nothing eligible clears both. `insn_done` while busy is ignored.
- R12: `exc_start` lasts one cycle per grant. `exc_grant` is always zero or one-hot. A grant at a `hdl_done` boundary follows with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst | input | 1 | Synchronous active-high reset; its release raises the reset exception |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| trace_en | input | 1 | Trace mode flag |
| irq | input | 1 | Interrupt request level |
| sleep_exec | input | 1 | Sleep instruction executed strobe |
| direct_mode | input | 1 | Direct-transition mode selected |
| trap_stb | input | 1 | Trap instruction strobe |
| insn_done | input | 1 | Instruction complete strobe |
| insn_cls | input | CLS_W | Class code of the completing instruction |
| hdl_done | input | 1 | Exception handler finished strobe |
| exc_grant | output | 5 | One-hot granted exception |
| exc_start | output | 1 | Single-cycle pulse on each grant |
| exc_busy | output | 1 | Handler in progress |

## Verification
The assertions take all inputs as synchronous to `clk`. They treat `hdl_done` as meaningful only while busy, and they take the strobes to be single-cycle pulses. The properties on interrupt masking and on busy holding still hold if `insn_done` arrives during a handler, because the block ignores it. The stimulus changes inputs only on the falling clock edge. It pulses each strobe for exactly one cycle and issues `hdl_done` only while a grant is active. A behavioural model of the ranking and masking rules is compared with the outputs every cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NEXC      = 5;
  localparam int EX_RST    = 0;
  localparam int EX_TRACE  = 1;
  localparam int EX_IRQ    = 2;
  localparam int EX_DIRECT = 3;
  localparam int EX_TRAP   = 4;
  // held request slots
  localparam int NHOLD     = 3;
  localparam int H_TRACE   = 0;
  localparam int H_DIRECT  = 1;
  localparam int H_TRAP    = 2;
  // instruction classes that block interrupt sampling
  localparam int CLS_CC_AND = 1;
  localparam int CLS_CC_OR  = 2;
  localparam int CLS_CC_XOR = 3;
  localparam int CLS_CC_LD  = 4;
endpackage

// File: rtl/exc_pend_bank.sv
module exc_pend_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic [N-1:0] set,
  input  logic [N-1:0] take,
  output logic [N-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst || flush) pend <= '0;
    else              pend <= (pend | set) & ~take;
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst) flush |=> pend == '0); // R3
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (rst) (take != '0) |=> ((pend & $past(take)) == '0)); // R4
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] win
);
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_rank
      if (gi == 0) begin : g_top
        assign win[gi] = req[gi];
      end else begin : g_low
        assign win[gi] = req[gi] & ~(|req[gi-1:0]);
      end
    end
  endgenerate
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int CLS_W = 3
) (
  input  logic             clk,
  input  logic             ext_rst,
  input  logic             wdt_ovf,
  input  logic             trace_en,
  input  logic             irq,
  input  logic             sleep_exec,
  input  logic             direct_mode,
  input  logic             trap_stb,
  input  logic             insn_done,
  input  logic [CLS_W-1:0] insn_cls,
  input  logic             hdl_done,
  output logic [NEXC-1:0]  exc_grant,
  output logic             exc_start,
  output logic             exc_busy
);
  localparam int NPICK = NEXC - 1;
  localparam logic [NEXC-1:0] RST_1H = NEXC'(1) << EX_RST;

  logic             rst_q;
  logic             insn_ok, hdl_ok, boundary, cls_flag, irq_mask, irq_ok;
  logic             rst_evt, fire;
  logic [NHOLD-1:0] hset, hpend, hcand, htake;
  logic [NPICK-1:0] req, win;

  assign insn_ok  = insn_done & ~exc_busy;
  assign hdl_ok   = hdl_done & exc_busy;
  assign boundary = insn_ok | hdl_ok;
  assign cls_flag = (int'(insn_cls) == CLS_CC_AND) || (int'(insn_cls) == CLS_CC_OR) ||
                    (int'(insn_cls) == CLS_CC_XOR) || (int'(insn_cls) == CLS_CC_LD);
  assign irq_mask = (insn_ok & cls_flag) | (hdl_ok & exc_grant[EX_RST]);
  assign irq_ok   = irq & ~irq_mask;
  assign rst_evt  = rst_q | wdt_ovf;

  assign hset[H_TRACE]  = insn_ok & trace_en;
  assign hset[H_DIRECT] = sleep_exec & direct_mode;
  assign hset[H_TRAP]   = trap_stb;
  assign hcand          = hpend | hset;

  // pick inputs ranked as grant bits 1..4
  assign req  = {hcand[H_TRAP], hcand[H_DIRECT], irq_ok, hcand[H_TRACE]};
  assign fire = boundary & (|req) & ~rst_evt;

  always_comb begin
    htake = '0;
    if (fire) begin
      htake[H_TRACE]  = win[EX_TRACE - 1];
      htake[H_DIRECT] = win[EX_DIRECT - 1];
      htake[H_TRAP]   = win[EX_TRAP - 1];
    end
  end

  exc_pend_bank #(.N(NHOLD)) u_hold (
    .clk(clk), .rst(ext_rst), .flush(rst_evt),
    .set(hset), .take(htake), .pend(hpend)
  );

  exc_prio_pick #(.N(NPICK)) u_pick (
    .req(req), .win(win)
  );

  always_ff @(posedge clk) begin
    if (ext_rst) begin
      rst_q     <= 1'b1;
      exc_grant <= '0;
      exc_start <= 1'b0;
      exc_busy  <= 1'b0;
    end else begin
      rst_q     <= 1'b0;
      exc_start <= 1'b0;
      if (rst_evt) begin
        exc_grant <= RST_1H;
        exc_start <= 1'b1;
        exc_busy  <= 1'b1;
      end else if (fire) begin
        exc_grant <= {win, 1'b0};
        exc_start <= 1'b1;
        exc_busy  <= 1'b1;
      end else if (hdl_ok) begin
        exc_grant <= '0;
        exc_busy  <= 1'b0;
      end
    end
  end

  AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (ext_rst) $onehot0(exc_grant)); // R12
  AST_START_HAS_GRANT: assert property (@(posedge clk) disable iff (ext_rst) exc_start |-> (exc_busy && $countones(exc_grant) == 1)); // R11
  AST_RELEASE_RESET: assert property (@(posedge clk) disable iff (ext_rst) $fell(ext_rst) |=> (exc_start && exc_grant == RST_1H)); // R2
  AST_WDT_RESET: assert property (@(posedge clk) disable iff (ext_rst) wdt_ovf |=> (exc_start && exc_grant == RST_1H)); // R3
  AST_FLAG_INSN_NO_IRQ: assert property (@(posedge clk) disable iff (ext_rst) (insn_done && !exc_busy && cls_flag) |=> !exc_grant[EX_IRQ]); // R7
  AST_RST_END_NO_IRQ: assert property (@(posedge clk) disable iff (ext_rst) (hdl_done && exc_busy && exc_grant[EX_RST]) |=> !exc_grant[EX_IRQ]); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (ext_rst) (exc_busy && !hdl_done && !wdt_ovf) |=> (exc_busy && $stable(exc_grant))); // R11
  AST_START_PULSE: assert property (@(posedge clk) disable iff (ext_rst) (exc_start && !hdl_done && !wdt_ovf) |=> !exc_start); // R12
endmodule

// File: tb/test_exc_arbiter.sv
module test_exc_arbiter;
  logic       clk = 1'b0;
  logic       ext_rst = 1'b1;
  logic       wdt_ovf = 1'b0, trace_en = 1'b0, irq = 1'b0, sleep_exec = 1'b0;
  logic       direct_mode = 1'b0, trap_stb = 1'b0, insn_done = 1'b0, hdl_done = 1'b0;
  logic [2:0] insn_cls = 3'd0;
  logic [4:0] exc_grant;
  logic       exc_start, exc_busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  exc_arbiter #(.CLS_W(3)) i_exc_arbiter (
    .clk(clk), .ext_rst(ext_rst), .wdt_ovf(wdt_ovf), .trace_en(trace_en), .irq(irq),
    .sleep_exec(sleep_exec), .direct_mode(direct_mode), .trap_stb(trap_stb),
    .insn_done(insn_done), .insn_cls(insn_cls), .hdl_done(hdl_done),
    .exc_grant(exc_grant), .exc_start(exc_start), .exc_busy(exc_busy)
  );

  // behavioural reference model
  integer     p_trace = 0, p_dir = 0, p_trap = 0, released = 1;
  logic [4:0] m_grant = 5'd0;
  logic       m_start = 1'b0, m_busy = 1'b0;

  always @(posedge clk) begin
    int  pick;
    bit  idle_done, bnd, masked;
    if (ext_rst) begin
      p_trace = 0; p_dir = 0; p_trap = 0; released = 1;
      m_grant = 5'd0; m_start = 1'b0; m_busy = 1'b0;
    end else begin
      idle_done = insn_done && !m_busy;
      if (idle_done && trace_en) p_trace = 1;
      if (sleep_exec && direct_mode) p_dir = 1;
      if (trap_stb) p_trap = 1;
      bnd    = idle_done || (hdl_done && m_busy);
      masked = (idle_done && insn_cls >= 3'd1 && insn_cls <= 3'd4) ||
               (hdl_done && m_busy && m_grant == 5'b00001);
      m_start = 1'b0;
      if (released != 0 || wdt_ovf) begin
        p_trace = 0; p_dir = 0; p_trap = 0;
        m_grant = 5'b00001; m_start = 1'b1; m_busy = 1'b1;
      end else begin
        pick = -1;
        if (bnd) begin
          if (p_trace != 0)         pick = 1;
          else if (irq && !masked)  pick = 2;
          else if (p_dir != 0)      pick = 3;
          else if (p_trap != 0)     pick = 4;
        end
        if (pick >= 0) begin
          m_grant = 5'(1 << pick); m_start = 1'b1; m_busy = 1'b1;
          if (pick == 1) p_trace = 0;
          if (pick == 3) p_dir = 0;
          if (pick == 4) p_trap = 0;
        end else if (hdl_done && m_busy) begin
          m_grant = 5'd0; m_busy = 1'b0;
        end
      end
      released = 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if ({exc_grant, exc_start, exc_busy} !== {m_grant, m_start, m_busy}) begin
        errors++;
        $display("FAIL R12 model compare: actual %b/%b/%b expected %b/%b/%b",
                 exc_grant, exc_start, exc_busy, m_grant, m_start, m_busy);
      end
    end
  end

  task automatic chk(input string req, input logic [4:0] g, input logic s, input logic b);
    checks++;
    if ({exc_grant, exc_start, exc_busy} !== {g, s, b}) begin
      errors++;
      $display("FAIL %s: actual grant=%b start=%b busy=%b expected grant=%b start=%b busy=%b",
               req, exc_grant, exc_start, exc_busy, g, s, b);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    insn_done = 1'b0; hdl_done = 1'b0; trap_stb = 1'b0; sleep_exec = 1'b0; wdt_ovf = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 held reset", 5'd0, 1'b0, 1'b0);
    trap_stb = 1'b1; cyc();
    chk("R1 trap during reset", 5'd0, 1'b0, 1'b0);
    ext_rst = 1'b0; cyc();
    chk("R2 release grant", 5'b00001, 1'b1, 1'b1);
    cyc();
    chk("R12 start one cycle", 5'b00001, 1'b0, 1'b1);
    trace_en = 1'b1; insn_done = 1'b1; cyc();
    chk("R11 insn ignored while busy", 5'b00001, 1'b0, 1'b1);
    trace_en = 1'b0; irq = 1'b1; hdl_done = 1'b1; cyc();
    chk("R8 no irq after reset handler", 5'd0, 1'b0, 1'b0);
    insn_done = 1'b1; insn_cls = 3'd0; cyc();
    chk("R6 irq at boundary", 5'b00100, 1'b1, 1'b1);
    irq = 1'b0; hdl_done = 1'b1; cyc();
    chk("R11 handler end", 5'd0, 1'b0, 1'b0);
    irq = 1'b1; cyc(); irq = 1'b0; insn_done = 1'b1; cyc();
    chk("R6 irq not stored", 5'd0, 1'b0, 1'b0);
    irq = 1'b1; insn_done = 1'b1; insn_cls = 3'd2; cyc();
    chk("R7 flag OR masks irq", 5'd0, 1'b0, 1'b0);
    insn_done = 1'b1; insn_cls = 3'd4; cyc();
    chk("R7 flag load masks irq", 5'd0, 1'b0, 1'b0);
    insn_done = 1'b1; insn_cls = 3'd5; cyc();
    chk("R7 other class takes irq", 5'b00100, 1'b1, 1'b1);
    irq = 1'b0; insn_cls = 3'd0; hdl_done = 1'b1; cyc();
    chk("R11 handler end 2", 5'd0, 1'b0, 1'b0);
    trace_en = 1'b1; irq = 1'b1; sleep_exec = 1'b1; direct_mode = 1'b1; trap_stb = 1'b1;
    insn_done = 1'b1; cyc();
    trace_en = 1'b0;
    chk("R5 trace wins all", 5'b00010, 1'b1, 1'b1);
    cyc();
    chk("R11 grant held", 5'b00010, 1'b0, 1'b1);
    hdl_done = 1'b1; cyc();
    chk("R4 irq next", 5'b00100, 1'b1, 1'b1);
    irq = 1'b0; hdl_done = 1'b1; cyc();
    chk("R9 direct next", 5'b01000, 1'b1, 1'b1);
    hdl_done = 1'b1; cyc();
    chk("R4 trap last", 5'b10000, 1'b1, 1'b1);
    hdl_done = 1'b1; cyc();
    chk("R4 queue empty", 5'd0, 1'b0, 1'b0);
    direct_mode = 1'b0;
    sleep_exec = 1'b1; insn_done = 1'b1; cyc();
    chk("R9 sleep without direct mode", 5'd0, 1'b0, 1'b0);
    trap_stb = 1'b1; insn_done = 1'b1; insn_cls = 3'd1; irq = 1'b1; cyc();
    chk("R10 trap not masked", 5'b10000, 1'b1, 1'b1);
    irq = 1'b0; insn_cls = 3'd0;
    trap_stb = 1'b1; cyc();
    chk("R11 trap held while busy", 5'b10000, 1'b0, 1'b1);
    hdl_done = 1'b1; cyc();
    chk("R10 trap from busy period", 5'b10000, 1'b1, 1'b1);
    hdl_done = 1'b1; cyc();
    chk("R10 done", 5'd0, 1'b0, 1'b0);
    trap_stb = 1'b1; insn_done = 1'b1; cyc();
    trap_stb = 1'b1; cyc();
    wdt_ovf = 1'b1; cyc();
    chk("R3 watchdog preempts", 5'b00001, 1'b1, 1'b1);
    irq = 1'b1; hdl_done = 1'b1; cyc();
    chk("R3 held trap discarded", 5'd0, 1'b0, 1'b0);
    insn_done = 1'b1; cyc();
    chk("R6 irq after watchdog", 5'b00100, 1'b1, 1'b1);
    irq = 1'b0; hdl_done = 1'b1; cyc();
    trap_stb = 1'b1; insn_done = 1'b1; cyc();
    ext_rst = 1'b1; cyc();
    chk("R1 reset mid handler", 5'd0, 1'b0, 1'b0);
    ext_rst = 1'b0; cyc();
    chk("R2 second release", 5'b00001, 1'b1, 1'b1);
    hdl_done = 1'b1; cyc();
    chk("R1 nothing held after reset", 5'd0, 1'b0, 1'b0);
    repeat (4) cyc();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule